// File: doc/BRIEF.md
# Command-Stepped I2C Master

This block is an I2C bus master that performs one bus primitive per software command instead of whole transfers. Software picks an operation code in a control byte and sets a launch bit in the same write. The block then does exactly one step: a start condition, a stop condition, an 8-bit send, an 8-bit receive, a single ACK or NAK bit sent, or a single acknowledge bit sampled. The launch bit reads back as a busy flag until the step ends. Software builds a full transfer by issuing these steps one after another.

A transmit holding byte feeds the shifter. It raises an empty flag, and optionally an interrupt, at the moment the byte is taken. A receive register keeps the last byte read from the bus. A status bit keeps the last acknowledge sampled. Both bus lines are open-drain: the block drives only output enables, and it reads SDA back through a two-stage synchronizer. A divider register sets the length of every SCL half period in clock cycles.

Top module: `i2c_step_master`

## Requirements
- R1: After reset the control byte (address 0) reads 0x00, the status byte (address 3) reads 0x00, `irq` is 0, and neither bus line is pulled low.
- R2: In the control byte, bits 2:0 hold the operation code and read back as written. Bit 4 reads as busy. Bits 7:5 and bit 3 always read 0. The codes are: 0 start, 1 stop, 2 send byte, 3 receive byte, 4 send ACK, 5 send NAK, 6 sample acknowledge, 7 no operation.
- R3: A step launches only on a control write with bit 4 set, while idle, and with master mode enabled (bit 0 of the config byte at address 4). A control write with bit 4 clear, or any write while master mode is off, starts nothing and leaves the bus untouched.
- R4: Busy reads 1 from the cycle after the launch until the step completes. A byte step with divider value D lasts 17*(D+1) cycles.
- R5: The start step releases SDA, then releases SCL, then pulls SDA low while SCL is high, and ends with SCL held low.
- R6: The stop step pulls SDA low while SCL is low, releases SCL, then releases SDA while SCL is high. Both lines end released.
- R7: The send step shifts the holding byte (address 1) out MSB first, one bit per SCL high phase. During send, receive and acknowledge steps, SDA changes only while SCL is low.
- R8: The empty flag (status bit 0) sets in the cycle after a send step launches. `irq` equals the flag ANDed with the enable bit (config bit 1). Writing 1 to status bit 0 clears the flag. Writing 0 there has no effect.
- R9: The receive step releases SDA and samples it at the end of each of 8 SCL high phases, MSB first. The byte can then be read at address 2.
- R10: The ACK step drives SDA low for one SCL clock. The NAK step leaves SDA released for one SCL clock.
- R11: The acknowledge-sample step releases SDA for one SCL clock and stores the level it sees in status bit 1 (0 = ACK, 1 = NAK).
- R12: Code 7 sets busy for exactly one cycle and leaves both bus lines unchanged.
- R13: Every SCL half period lasts D+1 clock cycles, where D is the divider register at address 5. D must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Transmit-empty interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
A wrong phase or sub-step counter shows up on the lines within one SCL half period. It appears as an extra or missing SDA edge while SCL is high, which a line monitor reads as a false start or stop, or as a high phase whose length differs from D+1 cycles. A shifter or bit-count fault appears at the end of the step as the wrong byte on the bus or in the receive register. A stuck busy state appears at once in the control readback: busy stays high past 17*(D+1) cycles, or a no-op leaves it set longer than one cycle. A fault in the empty flag appears in the status byte and on `irq` one cycle after the launch.

// File: rtl/i2c_step_master.sv
module i2c_step_master #(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam logic [2:0] OP_START = 3'd0, OP_STOP = 3'd1, OP_TX = 3'd2, OP_RX = 3'd3,
                         OP_ACK = 3'd4, OP_NAK = 3'd5, OP_ACKRX = 3'd6;
  localparam logic [2:0] A_CTRL = 3'd0, A_TX = 3'd1, A_RX = 3'd2, A_STAT = 3'd3,
                         A_CFG = 3'd4, A_DIV = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_NOP, S_START, S_STOP, S_BIT, S_TAIL} st_t;

  st_t              st;
  logic [2:0]       op_q, cur_op, bitn;
  logic [1:0]       sub, sda_sync;
  logic             half, scl_q, sda_q;
  logic [7:0]       shreg, txbuf, rxbuf, load;
  logic             txe, ack_st, master_en, txe_ie;
  logic [DIV_W-1:0] div_q, cnt;

  wire [2:0] sel      = reg_wdata[2:0];
  wire       busy     = (st != S_IDLE);
  wire       wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  wire       accept   = wr_ctrl && reg_wdata[4] && !busy && master_en;
  wire       tick     = (cnt == '0);
  wire       in_bitop = (st == S_BIT) || (st == S_TAIL);
  wire       sda_s    = sda_sync[1];

  assign scl_oe = scl_q;
  assign sda_oe = sda_q;
  assign irq    = txe & txe_ie;

  always_comb begin
    case (sel)
      OP_TX:   load = txbuf;
      OP_ACK:  load = 8'h00;
      default: load = 8'hFF;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {3'b000, busy, 1'b0, op_q};
      A_TX:    reg_rdata = txbuf;
      A_RX:    reg_rdata = rxbuf;
      A_STAT:  reg_rdata = {6'b0, ack_st, txe};
      A_CFG:   reg_rdata = {6'b0, txe_ie, master_en};
      A_DIV:   reg_rdata = 8'(div_q);
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_sync <= 2'b11;
    else        sda_sync <= {sda_sync[0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_START;
      txbuf     <= 8'h00;
      master_en <= 1'b0;
      txe_ie    <= 1'b0;
      div_q     <= DIV_W'(DIV_RST);
      txe       <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: op_q <= reg_wdata[2:0];
          A_TX:   txbuf <= reg_wdata;
          A_CFG:  begin master_en <= reg_wdata[0]; txe_ie <= reg_wdata[1]; end
          A_DIV:  div_q <= reg_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
      if (accept && sel == OP_TX)
        txe <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[0])
        txe <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur_op <= OP_START;
      sub    <= 2'd0;
      half   <= 1'b0;
      bitn   <= 3'd0;
      shreg  <= 8'hFF;
      cnt    <= '0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      rxbuf  <= 8'h00;
      ack_st <= 1'b0;
    end else if (accept) begin
      cur_op <= sel;
      cnt    <= div_q;
      sub    <= 2'd0;
      half   <= 1'b0;
      case (sel)
        OP_START: begin st <= S_START; scl_q <= 1'b1; end
        OP_STOP:  begin st <= S_STOP;  scl_q <= 1'b1; end
        OP_TX, OP_RX, OP_ACK, OP_NAK, OP_ACKRX: begin
          st    <= S_BIT;
          scl_q <= 1'b1;
          shreg <= load;
          bitn  <= (sel == OP_TX || sel == OP_RX) ? 3'd7 : 3'd0;
        end
        default: st <= S_NOP;
      endcase
    end else begin
      if (st != S_IDLE && st != S_NOP)
        cnt <= tick ? div_q : cnt - 1'b1;
      case (st)
        S_NOP: st <= S_IDLE;
        S_START: begin
          if (sub == 2'd0) sda_q <= 1'b0;
          if (tick) begin
            sub <= sub + 1'b1;
            case (sub)
              2'd0:    scl_q <= 1'b0;
              2'd1:    sda_q <= 1'b1;
              2'd2:    scl_q <= 1'b1;
              default: st <= S_IDLE;
            endcase
          end
        end
        S_STOP: begin
          if (sub == 2'd0) sda_q <= 1'b1;
          if (tick) begin
            sub <= sub + 1'b1;
            case (sub)
              2'd0:    scl_q <= 1'b0;
              2'd1:    sda_q <= 1'b0;
              default: st <= S_IDLE;
            endcase
          end
        end
        S_BIT: begin
          if (!half) sda_q <= ~shreg[7];
          if (tick) begin
            if (!half) begin
              half  <= 1'b1;
              scl_q <= 1'b0;
            end else begin
              half  <= 1'b0;
              scl_q <= 1'b1;
              shreg <= {shreg[6:0], sda_s};
              if (bitn == 3'd0) begin
                st <= S_TAIL;
                if (cur_op == OP_RX)    rxbuf  <= {shreg[6:0], sda_s};
                if (cur_op == OP_ACKRX) ack_st <= sda_s;
              end else begin
                bitn <= bitn - 1'b1;
              end
            end
          end
        end
        S_TAIL: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_step_master_chk.sv
module i2c_step_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       accept,
  input logic [2:0] sel,
  input logic       in_bitop,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       txe,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic       master_en,
  input logic [7:0] reg_rdata
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> (reg_rdata[7:5] == 3'b000 && !reg_rdata[3]));

  p_ignore_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !master_en && !busy) |=> !busy);

  p_busy_after_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_sda_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bitop && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  p_txe_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txe) |-> $past(accept && sel == 3'd2));

  p_nop_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel == 3'd7) |=> (busy ##1 !busy));
endmodule

bind i2c_step_master i2c_step_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .accept(accept), .sel(reg_wdata[2:0]),
  .in_bitop(in_bitop), .scl_oe(scl_oe), .sda_oe(sda_oe), .txe(txe),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .master_en(master_en), .reg_rdata(reg_rdata)
);

// File: tb/i2c_step_master_tb.sv
`timescale 1ns/1ps
module i2c_step_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       pull = 1'b0;
  wire        scl_line = ~scl_oe;
  wire        sda_line = ~(sda_oe | pull);

  int checks = 0, errors = 0;
  int start_cnt = 0, stop_cnt = 0, bit_cnt = 0, hi_run = 0, last_hi = 0;
  logic [15:0] bits = '0;
  logic scl_prev = 1'b1, sda_prev = 1'b1;

  always #10 clk = ~clk;

  i2c_step_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  always @(negedge clk) begin
    if (scl_prev && scl_line) begin
      if (sda_prev && !sda_line) start_cnt++;
      if (!sda_prev && sda_line) stop_cnt++;
    end
    if (!scl_prev && scl_line) begin
      bits = {bits[14:0], sda_line};
      bit_cnt++;
    end
    if (scl_line) hi_run++;
    else begin
      if (scl_prev) last_hi = hi_run;
      hi_run = 0;
    end
    scl_prev = scl_line;
    sda_prev = sda_line;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(3'd0, v);
      if (!v[4]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 8'h00);
    rd(3'd3, v); check("R1 status", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 lines", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    wr(3'd0, 8'h12);
    rd(3'd0, v); check("R3 master off no busy", v[4], 0);
    check("R3 master off bus", {scl_oe, sda_oe}, 0);
    check("R2 op readback", v[2:0], 2);
    wr(3'd4, 8'h03);
    wr(3'd0, 8'h02);
    rd(3'd0, v); check("R3 write0 no launch", v[4], 0);
    check("R3 write0 bus", {scl_oe, sda_oe}, 0);
    wr(3'd0, 8'hEA);
    rd(3'd0, v); check("R2 reserved bits", v, 8'h02);
  endtask

  task automatic t_start();
    int s0 = start_cnt;
    wr(3'd0, 8'h10);
    wait_idle();
    check("R5 start seen", start_cnt, s0 + 1);
    check("R5 scl held low", scl_oe, 1);
  endtask

  task automatic t_tx(input logic [7:0] b);
    logic [7:0] v;
    int s0 = start_cnt, p0 = stop_cnt;
    bit_cnt = 0;
    wr(3'd1, b);
    wr(3'd0, 8'h12);
    rd(3'd3, v); check("R8 empty set", v[0], 1);
    check("R8 irq", irq, 1);
    repeat (66) @(negedge clk);
    rd(3'd0, v); check("R4 busy late", v[4], 1);
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R4 done", v[4], 0);
    check("R7 bit count", bit_cnt, 8);
    check("R7 byte", bits[7:0], b);
    check("R7 no edge under high scl", start_cnt + stop_cnt, s0 + p0);
    check("R13 high length", last_hi, 4);
    wr(3'd3, 8'h00);
    rd(3'd3, v); check("R8 write0 ignored", v[0], 1);
    wr(3'd3, 8'h01);
    rd(3'd3, v); check("R8 w1c", v[0], 0);
    check("R8 irq clear", irq, 0);
  endtask

  task automatic t_ackrx(input logic p, input int exp);
    logic [7:0] v;
    pull = p;
    wr(3'd0, 8'h16);
    wait_idle();
    pull = 1'b0;
    rd(3'd3, v); check("R11 ack status", v[1], exp);
  endtask

  task automatic t_rx(input logic [7:0] b);
    logic [7:0] v;
    wr(3'd0, 8'h13);
    for (int i = 7; i >= 0; i--) begin
      pull = ~b[i];
      while (!scl_line) @(negedge clk);
      while (scl_line) @(negedge clk);
    end
    pull = 1'b0;
    wait_idle();
    rd(3'd2, v); check("R9 rx byte", v, b);
    rd(3'd3, v); check("R9 rx leaves empty flag", v[0], 0);
  endtask

  task automatic t_acktx(input logic [7:0] cmd, input int exp);
    int b0 = bit_cnt;
    wr(3'd0, cmd);
    wait_idle();
    check("R10 one bit", bit_cnt, b0 + 1);
    check("R10 bit level", bits[0], exp);
  endtask

  task automatic t_nop();
    logic [7:0] v;
    logic [1:0] ln = {scl_oe, sda_oe};
    wr(3'd0, 8'h17);
    rd(3'd0, v); check("R12 busy one cycle", v[4], 1);
    @(negedge clk);
    rd(3'd0, v); check("R12 busy cleared", v[4], 0);
    check("R12 bus unchanged", {scl_oe, sda_oe}, ln);
  endtask

  task automatic t_stop();
    int p0 = stop_cnt;
    wr(3'd0, 8'h11);
    wait_idle();
    check("R6 stop seen", stop_cnt, p0 + 1);
    check("R6 lines released", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignore();
    wr(3'd5, 8'd3);
    t_start();
    t_tx(8'hA5);
    t_ackrx(1'b1, 0);
    t_tx(8'h3C);
    t_ackrx(1'b0, 1);
    t_rx(8'hC3);
    t_acktx(8'h14, 0);
    t_rx(8'h5A);
    t_acktx(8'h15, 1);
    t_nop();
    t_stop();
    t_start();
    t_stop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule